// File: doc/BRIEF.md
# Clock Calibration Master Controller

This block brings a set of local clock generators to their target frequencies, one generator after another. The generators share one daisy-chained, low-speed synchronous serial link, and each has its own address on that link. A built-in constant table holds the settings for each generator: its link address, its initial divider value, the length of its measurement window, its target count and its tolerance. The controller works through the table in entry order. For each generator it sends one programming frame, then repeats a measure-and-trim loop until the measured count is close enough to the target or until the trim budget is used up.

A measurement opens a window of a fixed number of reference cycles, signalled on `meas_en`. Counting local clock edges during that window happens outside the block, and the result arrives on `meas_count`. After each measurement the controller either moves to the next generator or sends one small trim step up or down. When the last generator is finished, `done` rises. A `start` pulse runs the whole job again from the first entry.

Top module: `clkcal_master`

## Requirements
- R1: While `rst` is high, and afterwards until the first `start`, `done`, `err_flags`, `ser_frame`, `ser_clk` and `meas_en` are all 0.
- R2: A frame is 26 bits sent MSB first: 8-bit address, then 2-bit opcode, then 16-bit payload. `ser_frame` stays high for exactly 26*BIT_DIV cycles. `ser_clk` rises once per bit, only while `ser_frame` is high, and `ser_data` does not change while `ser_clk` is high.
- R3: Opcode 01 means program, 10 means increment and 11 means decrement. Every increment or decrement frame carries payload 1.
- R4: Table entry i holds address 0x20+5i, divider 0x0100+0x11i, window 8+2i cycles, target 100+10i and tolerance 2. Entries are handled in order 0..NUM_GEN-1. The first frame for each entry is a program frame that carries that entry's address and divider, and it is sent before any measurement of that entry.
- R5: Each measurement raises `meas_en` for exactly the entry's window length. `meas_count` is sampled in the cycle that follows the fall of `meas_en`.
- R6: When the sampled count lies in [target-tol, target+tol], bounds included, no trim frame is sent and the next entry begins.
- R7: When the count is below that band, one increment frame goes to the entry's address. When it is above, one decrement frame goes there. After either frame a new measurement follows.
- R8: An entry gets at most MAX_TRIM trim frames. If the count is still outside the band after that many trims, bit i of `err_flags` is set and the next entry begins.
- R9: `done` rises after the last entry has been handled and stays high until `start`. While `done` is high, the link and the window are idle.
- R10: A `start` pulse in any state clears `done` and `err_flags`, ends any frame or window in progress, and restarts the sequence from entry 0.
- R11: `ser_frame` and `meas_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts or restarts the calibration sequence |
| meas_count | input | 16 | Local clock edge count for the window that just ended |
| ser_clk | output | 1 | Serial bit clock, high in the second half of each bit |
| ser_data | output | 1 | Serial frame data, MSB first |
| ser_frame | output | 1 | High for the whole duration of a frame |
| meas_en | output | 1 | Measurement window is open |
| done | output | 1 | All table entries have been handled |
| err_flags | output | NUM_GEN | Per-entry flag: trim budget ran out |

## Verification
The checker watches the link framing on every cycle: frame length, `ser_clk` appearing only inside a frame, and `ser_data` holding steady while `ser_clk` is high. On every cycle it also checks that a frame and a window never overlap, that error flags only ever get set, that `done` is held and leaves the link idle, and that `start` clears the block. The frame contents, the entry order and the tolerance boundaries, along with trim direction, trim count and timeout, can only be shown by the bench. It does this with a generator model whose count responds to the decoded trim frames: one entry is in band at once, two land exactly on the lower and upper band edges, and one never converges. The bench also drives a wrong count on every cycle except the one in which sampling is allowed.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;

    localparam int ADDR_W  = 8;
    localparam int OP_W    = 2;
    localparam int PAY_W   = 16;
    localparam int CNT_W   = 16;
    localparam int FRAME_W = ADDR_W + OP_W + PAY_W;

    typedef enum logic [OP_W-1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_INC  = 2'b10,
        OP_DEC  = 2'b11
    } op_e;

    // Field order is the wire order: address leaves first.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        op_e               op;
        logic [PAY_W-1:0]  payload;
    } frame_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [PAY_W-1:0]  div;
        logic [CNT_W-1:0]  win_len;
        logic [CNT_W-1:0]  target;
        logic [CNT_W-1:0]  tol;
    } gen_cfg_t;

    typedef enum logic [1:0] {
        CMP_LOW  = 2'd0,
        CMP_OK   = 2'd1,
        CMP_HIGH = 2'd2
    } cmp_e;

    localparam logic [PAY_W-1:0] TRIM_STEP = PAY_W'(1);

    // Constant table contents, computed per entry.
    function automatic gen_cfg_t table_entry(input int unsigned i);
        gen_cfg_t e;
        e.addr    = ADDR_W'(32'h20 + 5 * i);
        e.div     = PAY_W'(32'h0100 + 32'h11 * i);
        e.win_len = CNT_W'(8 + 2 * i);
        e.target  = CNT_W'(100 + 10 * i);
        e.tol     = CNT_W'(2);
        return e;
    endfunction

    function automatic cmp_e classify(input logic [CNT_W-1:0] cnt,
                                      input logic [CNT_W-1:0] tgt,
                                      input logic [CNT_W-1:0] tol);
        logic [CNT_W:0] c_up;
        logic [CNT_W:0] t_up;
        c_up = {1'b0, cnt} + {1'b0, tol};
        t_up = {1'b0, tgt} + {1'b0, tol};
        if (c_up < {1'b0, tgt})
            return CMP_LOW;
        else if ({1'b0, cnt} > t_up)
            return CMP_HIGH;
        else
            return CMP_OK;
    endfunction

endpackage

// File: rtl/clkcal_rom.sv
module clkcal_rom
    import clkcal_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int IDX_W   = 2
) (
    input  logic [IDX_W-1:0] idx,
    output gen_cfg_t         cfg
);

    gen_cfg_t mem [NUM_GEN];

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_ent
        assign mem[g] = table_entry(g);
    end

    always_comb begin
        cfg = '0;
        for (int i = 0; i < NUM_GEN; i++) begin
            if (idx == IDX_W'(i))
                cfg = mem[i];
        end
    end

endmodule

// File: rtl/clkcal_ser.sv
module clkcal_ser
    import clkcal_pkg::*;
#(
    parameter int BIT_DIV = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   abort,
    input  logic   go,
    input  frame_t frame_in,
    output logic   ser_clk,
    output logic   ser_data,
    output logic   ser_frame,
    output logic   done
);

    localparam int DIV_W = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BIT_DIV - 1);
    localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(BIT_DIV / 2);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

    logic               active;
    logic [DIV_W-1:0]   div_cnt;
    logic [BIT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active  <= 1'b0;
            done    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            done <= 1'b0;
            if (go && !active) begin
                active  <= 1'b1;
                shreg   <= frame_in;
                div_cnt <= '0;
                bit_cnt <= '0;
            end else if (active) begin
                if (div_cnt == DIV_LAST) begin
                    div_cnt <= '0;
                    if (bit_cnt == BIT_LAST) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

    assign ser_frame = active;
    assign ser_data  = active & shreg[FRAME_W-1];
    assign ser_clk   = active && (div_cnt >= DIV_HALF);

endmodule

// File: rtl/clkcal_meas.sv
module clkcal_meas
    import clkcal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             go,
    input  logic [CNT_W-1:0] win_len,
    input  logic [CNT_W-1:0] target,
    input  logic [CNT_W-1:0] tol,
    input  logic [CNT_W-1:0] count_in,
    output logic             meas_en,
    output logic             valid,
    output cmp_e             cmp
);

    logic [CNT_W-1:0] left;
    logic             pend;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            meas_en <= 1'b0;
            left    <= '0;
            pend    <= 1'b0;
            valid   <= 1'b0;
            cmp     <= CMP_OK;
        end else begin
            valid <= 1'b0;
            if (go && !meas_en && !pend) begin
                meas_en <= 1'b1;
                left    <= win_len;
            end else if (meas_en) begin
                if (left <= CNT_W'(1)) begin
                    meas_en <= 1'b0;
                    pend    <= 1'b1;
                end else begin
                    left <= left - 1'b1;
                end
            end else if (pend) begin
                pend  <= 1'b0;
                valid <= 1'b1;
                cmp   <= classify(count_in, target, tol);
            end
        end
    end

endmodule

// File: rtl/clkcal_master.sv
module clkcal_master
    import clkcal_pkg::*;
#(
    parameter int NUM_GEN  = 4,
    parameter int BIT_DIV  = 4,
    parameter int MAX_TRIM = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [15:0]        meas_count,
    output logic               ser_clk,
    output logic               ser_data,
    output logic               ser_frame,
    output logic               meas_en,
    output logic               done,
    output logic [NUM_GEN-1:0] err_flags
);

    localparam int IDX_W = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;
    localparam int TR_W  = $clog2(MAX_TRIM + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_GEN - 1);
    localparam logic [TR_W-1:0]  TR_MAX   = TR_W'(MAX_TRIM);

    typedef enum logic [3:0] {
        S_IDLE, S_LOAD, S_SEND, S_PROG, S_MEAS, S_WAIT, S_TRIM, S_NEXT, S_DONE
    } state_e;

    state_e             st;
    logic [IDX_W-1:0]   idx;
    gen_cfg_t           cfg;
    gen_cfg_t           rom_q;
    logic [TR_W-1:0]    trims;
    logic [NUM_GEN-1:0] err_q;
    logic               done_q;

    frame_t tx_frame;
    logic   tx_go;
    logic   tx_done;
    logic   m_go;
    logic   m_valid;
    cmp_e   m_cmp;
    logic   trim_req;

    clkcal_rom #(.NUM_GEN(NUM_GEN), .IDX_W(IDX_W)) u_rom (
        .idx (idx),
        .cfg (rom_q)
    );

    assign trim_req = (st == S_WAIT) && m_valid && (m_cmp != CMP_OK) && (trims != TR_MAX);
    assign tx_go    = !start && ((st == S_SEND) || trim_req);
    assign m_go     = !start && (st == S_MEAS);

    always_comb begin
        tx_frame.addr = cfg.addr;
        if (st == S_SEND) begin
            tx_frame.op      = OP_PROG;
            tx_frame.payload = cfg.div;
        end else begin
            tx_frame.op      = (m_cmp == CMP_LOW) ? OP_INC : OP_DEC;
            tx_frame.payload = TRIM_STEP;
        end
    end

    clkcal_ser #(.BIT_DIV(BIT_DIV)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .abort    (start),
        .go       (tx_go),
        .frame_in (tx_frame),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_frame(ser_frame),
        .done     (tx_done)
    );

    clkcal_meas u_meas (
        .clk      (clk),
        .rst      (rst),
        .abort    (start),
        .go       (m_go),
        .win_len  (cfg.win_len),
        .target   (cfg.target),
        .tol      (cfg.tol),
        .count_in (meas_count),
        .meas_en  (meas_en),
        .valid    (m_valid),
        .cmp      (m_cmp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            idx    <= '0;
            cfg    <= '0;
            trims  <= '0;
            err_q  <= '0;
            done_q <= 1'b0;
        end else if (start) begin
            st     <= S_LOAD;
            idx    <= '0;
            trims  <= '0;
            err_q  <= '0;
            done_q <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: ;
                S_LOAD: begin
                    cfg <= rom_q;
                    st  <= S_SEND;
                end
                S_SEND: st <= S_PROG;
                S_PROG: begin
                    if (tx_done) begin
                        trims <= '0;
                        st    <= S_MEAS;
                    end
                end
                S_MEAS: st <= S_WAIT;
                S_WAIT: begin
                    if (m_valid) begin
                        if (m_cmp == CMP_OK) begin
                            st <= S_NEXT;
                        end else if (trims == TR_MAX) begin
                            err_q[idx] <= 1'b1;
                            st         <= S_NEXT;
                        end else begin
                            trims <= trims + 1'b1;
                            st    <= S_TRIM;
                        end
                    end
                end
                S_TRIM: if (tx_done) st <= S_MEAS;
                S_NEXT: begin
                    if (idx == IDX_LAST) begin
                        done_q <= 1'b1;
                        st     <= S_DONE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= S_LOAD;
                    end
                end
                S_DONE: ;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign done      = done_q;
    assign err_flags = err_q;

endmodule

// File: rtl/clkcal_master_chk.sv
module clkcal_master_chk #(
    parameter int NUM_GEN  = 4,
    parameter int BIT_DIV  = 4,
    parameter int MAX_TRIM = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               ser_clk,
    input logic               ser_data,
    input logic               ser_frame,
    input logic               meas_en,
    input logic               done,
    input logic [NUM_GEN-1:0] err_flags
);

    localparam int FRAME_CYC = 26 * BIT_DIV;

    logic [15:0] flen;

    always_ff @(posedge clk) begin
        if (rst || !ser_frame)
            flen <= '0;
        else
            flen <= flen + 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!done && err_flags == '0 && !ser_frame && !meas_en));

    a_r2_frame_len: assert property (@(posedge clk) disable iff (rst)
        ser_frame |-> (flen < 16'(FRAME_CYC)));

    a_r2_clk_in_frame: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> ser_frame);

    a_r2_data_stable: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        !start |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ser_frame && !meas_en));

    a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && err_flags == '0 && !ser_frame && !meas_en));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ser_frame && meas_en));

endmodule

bind clkcal_master clkcal_master_chk #(
    .NUM_GEN (NUM_GEN),
    .BIT_DIV (BIT_DIV),
    .MAX_TRIM(MAX_TRIM)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_frame(ser_frame),
    .meas_en  (meas_en),
    .done     (done),
    .err_flags(err_flags)
);

// File: tb/test_clkcal_master.sv
module test_clkcal_master;

    localparam int NG = 4;
    localparam int BD = 4;
    localparam int MT = 64;
    localparam int TOL = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   meas_count;
    logic          ser_clk, ser_data, ser_frame, meas_en, done;
    logic [NG-1:0] err_flags;

    always #2 clk = ~clk;

    clkcal_master #(.NUM_GEN(NG), .BIT_DIV(BD), .MAX_TRIM(MT)) i_clkcal_master (
        .clk(clk), .rst(rst), .start(start), .meas_count(meas_count),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_frame(ser_frame),
        .meas_en(meas_en), .done(done), .err_flags(err_flags)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int t_addr(int g); return 32'h20 + 5 * g; endfunction
    function automatic int t_div(int g);  return 32'h100 + 32'h11 * g; endfunction
    function automatic int t_win(int g);  return 8 + 2 * g; endfunction
    function automatic int t_tgt(int g);  return 100 + 10 * g; endfunction

    // Generator model: entry 3 never moves, the others step by 3 per trim.
    function automatic int model_count(int g, int k);
        case (g)
            0: return t_tgt(g);
            1: return t_tgt(g) - 20 + 3 * k;
            2: return t_tgt(g) + 14 + 3 * k;
            default: return t_tgt(g) + 50;
        endcase
    endfunction

    int exp_addr [0:511];
    int exp_op   [0:511];
    int exp_pay  [0:511];
    int nexp;
    int exp_err;

    int fr_addr [0:511];
    int fr_op   [0:511];
    int fr_pay  [0:511];
    int nfr = 0;
    int cur_g = 0;
    int trim_k = 0;

    logic men_d = 1'b0;
    always @(posedge clk) men_d <= meas_en;

    always_comb begin
        if (men_d && !meas_en)
            meas_count = 16'(model_count(cur_g, trim_k));
        else
            meas_count = 16'hDEAD;
    end

    // Link and window monitor
    logic        sf_d = 1'b0, sc_d = 1'b0, me_d2 = 1'b0;
    logic [25:0] shreg = '0;
    int          bitcnt = 0, flen = 0, wlen = 0;

    always @(negedge clk) begin
        if (ser_frame && !sf_d) begin
            bitcnt = 0;
            flen   = 0;
            shreg  = '0;
        end
        if (ser_frame) flen++;
        if (ser_frame && ser_clk && !sc_d) begin
            shreg = {shreg[24:0], ser_data};
            bitcnt++;
        end
        if (!ser_frame && sf_d && bitcnt == 26) begin
            chk(flen == 26 * BD, "R2 frame length", flen, 26 * BD);
            fr_addr[nfr] = int'(shreg[25:18]);
            fr_op[nfr]   = int'(shreg[17:16]);
            fr_pay[nfr]  = int'(shreg[15:0]);
            if (fr_op[nfr] == 1) begin
                for (int g = 0; g < NG; g++)
                    if (t_addr(g) == fr_addr[nfr]) cur_g = g;
                trim_k = 0;
            end else if (fr_op[nfr] == 2) begin
                trim_k++;
            end else if (fr_op[nfr] == 3) begin
                trim_k--;
            end
            if (nfr < 511) nfr++;
        end
        if (meas_en) wlen++;
        if (!meas_en && me_d2) begin
            chk(wlen == t_win(cur_g), "R5 window length", wlen, t_win(cur_g));
            wlen = 0;
        end
        sf_d  = ser_frame;
        sc_d  = ser_clk;
        me_d2 = meas_en;
    end

    task automatic build_expected();
        nexp = 0;
        exp_err = 0;
        for (int g = 0; g < NG; g++) begin
            int k;
            k = 0;
            exp_addr[nexp] = t_addr(g); exp_op[nexp] = 1; exp_pay[nexp] = t_div(g); nexp++;
            for (int t = 0; t <= MT; t++) begin
                int c;
                c = model_count(g, k);
                if (c >= t_tgt(g) - TOL && c <= t_tgt(g) + TOL) break;
                if (t == MT) begin
                    exp_err |= (1 << g);
                    break;
                end
                exp_addr[nexp] = t_addr(g);
                exp_pay[nexp]  = 1;
                if (c < t_tgt(g) - TOL) begin exp_op[nexp] = 2; k++; end
                else begin exp_op[nexp] = 3; k--; end
                nexp++;
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(done == 1'b0, "R10 done cleared", int'(done), 0);
        chk(err_flags == '0, "R10 errors cleared", int'(err_flags), 0);
        chk(ser_frame == 1'b0, "R10 frame aborted", int'(ser_frame), 0);
        nfr = 0;
        trim_k = 0;
        cur_g = 0;
    endtask

    task automatic verify_run();
        while (!done) @(negedge clk);
        chk(nfr == nexp, "R4 R8 frame total", nfr, nexp);
        for (int i = 0; i < nexp && i < nfr; i++) begin
            chk(fr_addr[i] == exp_addr[i], "R4 frame address", fr_addr[i], exp_addr[i]);
            chk(fr_op[i] == exp_op[i], "R3 R7 frame opcode", fr_op[i], exp_op[i]);
            chk(fr_pay[i] == exp_pay[i], "R3 R4 frame payload", fr_pay[i], exp_pay[i]);
        end
        chk(int'(err_flags) == exp_err, "R8 timeout flags", int'(err_flags), exp_err);
        repeat (50) @(negedge clk);
        chk(done == 1'b1, "R9 done held", int'(done), 1);
        chk(nfr == nexp, "R9 link idle after done", nfr, nexp);
    endtask

    initial begin
        build_expected();
        chk(nexp == 4 + 6 + 4 + MT, "R6 R7 R8 expected plan size", nexp, 4 + 6 + 4 + MT);
        repeat (4) @(negedge clk);
        chk(done == 1'b0 && err_flags == '0, "R1 reset outputs", int'(done), 0);
        chk(ser_frame == 1'b0 && meas_en == 1'b0, "R1 reset link idle", int'(ser_frame), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(ser_frame == 1'b0 && meas_en == 1'b0 && done == 1'b0,
            "R1 idle before start", int'(ser_frame), 0);

        pulse_start();
        verify_run();

        pulse_start();
        while (nfr < 12) @(negedge clk);
        while (!ser_frame) @(negedge clk);
        repeat (7) @(negedge clk);
        pulse_start();
        verify_run();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual no done expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule